// File: doc/BRIEF.md
# I2C Register-File Target

This block answers a fixed 7-bit I2C address and moves bytes between the bus and two small register files. A local CPU reaches these files as 32-bit words. Bytes written by the bus controller land in a receive file at a hardware write pointer. Bytes the controller reads are taken from a transmit file at a hardware read pointer. Both pointers advance one byte at a time and wrap around the file.

SCL and SDA are sampled with the system clock through two-flop synchronizers. The block detects START and STOP from the sampled lines. It drives SDA only by pulling it low (`sda_oe` = 1 means pull low). When a write segment ends with a STOP, a sticky status bit is set. The interrupt output is that bit gated by an enable bit.

CPU word map at the default size (64-byte files): addresses 0x00–0x0F are receive words, 0x10–0x1F are transmit words, 0x20 is the write pointer, 0x21 is the read pointer, 0x22 bit 0 is the interrupt enable, and 0x23 bit 0 is the status bit. Unmapped addresses read as zero.

Top module: `i2c_regfile_target`

## Requirements
- R1: An address byte whose upper seven bits equal 0x50 is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and SDA stays released until the next START.
- R2: Each data byte of a write segment is acknowledged and stored in the receive file at the write pointer p. It goes in word p>>2, bits 8*(p&3)+7 down to 8*(p&3), and then p advances by one.
- R3: In a read segment (address byte bit 0 = 1), bytes are sent MSB first from the transmit file at the read pointer, using the same lane mapping as R2. The read pointer advances by one for each byte loaded.
- R4: Both pointers wrap modulo 64, so byte 63 is followed by byte 0 of word 0.
- R5: The CPU can write either pointer (address 0x20 or 0x21) and read it back. Writing zero returns the pointer to the start of its file. A CPU pointer write takes priority over a bus increment in the same cycle.
- R6: A STOP that ends an acknowledged write segment sets the status bit. Writing 1 to bit 0 of 0x23 clears it, and writing 0 has no effect. `irq` equals enable AND status. A read segment never sets status.
- R7: After the controller NACKs a read byte, the target releases SDA and drives nothing more until the next START.
- R8: A repeated START resets the bit count and returns to address reception. The segment it ends does not set status.
- R9: After reset, both pointers, the enable bit, the status bit, `irq` and `sda_oe` are zero.
- R10: CPU writes to the transmit words are stored and read back. A transmit word preset to 0xFFFFFFFF makes every byte read from it 0xFF. CPU writes to receive words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 pulls SDA low |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 6 | CPU word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, combinational from `cpu_addr` |
| irq | output | 1 | Write-complete interrupt |

## Verification
The assertions assume that each SCL phase lasts several system clocks, so that the synchronizer delay never merges a rising and a falling edge. They also assume that SDA changes only while SCL is low, except at START and STOP. The bench controller holds every quarter of an SCL bit for six clocks. It changes SDA only a full quarter after SCL falls, by which point the target has already updated `sda_oe`. CPU accesses are applied between bus events and never coincide with a pointer increment.

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [6:0] TARGET_ADDR = 7'h50,
  parameter int FILE_BYTES = 64,
  localparam int CPU_AW = $clog2(FILE_BYTES / 2 + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              irq
);
  localparam int WORDS = FILE_BYTES / 4;
  localparam int PW = $clog2(FILE_BYTES);
  localparam int WW = $clog2(WORDS);
  localparam logic [CPU_AW-1:0] A_TX = CPU_AW'(WORDS);
  localparam logic [CPU_AW-1:0] A_WP = CPU_AW'(2 * WORDS);
  localparam logic [CPU_AW-1:0] A_RP = CPU_AW'(2 * WORDS + 1);
  localparam logic [CPU_AW-1:0] A_EN = CPU_AW'(2 * WORDS + 2);
  localparam logic [CPU_AW-1:0] A_ST = CPU_AW'(2 * WORDS + 3);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_SKIP
  } st_t;

  st_t st;
  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  logic [31:0] rx_mem [WORDS];
  logic [31:0] tx_mem [WORDS];
  logic [PW-1:0] wp, rp;
  logic [3:0] cnt;
  logic [7:0] sh, tsh;
  logic rw, wr_act, irq_en, irq_st;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_evt = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_evt = scl_s & scl_q & ~sda_q & sda_s;

  wire [31:0] tx_word = tx_mem[rp[PW-1:2]];
  wire [7:0] tx_byte = tx_word[{rp[1:0], 3'b000} +: 8];

  wire cpu_tx_wr = cpu_we && cpu_addr >= A_TX && cpu_addr < A_WP;
  wire cpu_wp_wr = cpu_we && cpu_addr == A_WP;
  wire cpu_rp_wr = cpu_we && cpu_addr == A_RP;
  wire cpu_clr = cpu_we && cpu_addr == A_ST && cpu_wdata[0];

  assign irq = irq_en & irq_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sda_oe <= 1'b0;
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      sh <= '0;
      tsh <= '0;
      rw <= 1'b0;
      wr_act <= 1'b0;
      irq_en <= 1'b0;
      irq_st <= 1'b0;
      for (int i = 0; i < WORDS; i++) begin
        rx_mem[i] <= '0;
        tx_mem[i] <= '0;
      end
    end else begin
      if (cpu_tx_wr) tx_mem[cpu_addr[WW-1:0]] <= cpu_wdata;
      if (cpu_we && cpu_addr == A_EN) irq_en <= cpu_wdata[0];
      if (stop_evt && wr_act) irq_st <= 1'b1;
      else if (cpu_clr) irq_st <= 1'b0;

      if (start_evt) begin
        st <= S_ADDR;
        cnt <= '0;
        sda_oe <= 1'b0;
        wr_act <= 1'b0;
      end else if (stop_evt) begin
        st <= S_IDLE;
        sda_oe <= 1'b0;
        wr_act <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          S_ADDR, S_WDAT: begin
            sh <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end
          S_RDAT: cnt <= cnt + 4'd1;
          S_RACK: if (sda_s) st <= S_SKIP;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          S_ADDR: if (cnt == 4'd8) begin
            if (sh[7:1] == TARGET_ADDR) begin
              st <= S_AACK;
              sda_oe <= 1'b1;
              rw <= sh[0];
              wr_act <= ~sh[0];
            end else begin
              st <= S_SKIP;
            end
          end
          S_AACK: begin
            cnt <= '0;
            if (rw) begin
              tsh <= tx_byte;
              sda_oe <= ~tx_byte[7];
              rp <= rp + 1'b1;
              st <= S_RDAT;
            end else begin
              sda_oe <= 1'b0;
              st <= S_WDAT;
            end
          end
          S_WDAT: if (cnt == 4'd8) begin
            rx_mem[wp[PW-1:2]][{wp[1:0], 3'b000} +: 8] <= sh;
            wp <= wp + 1'b1;
            sda_oe <= 1'b1;
            st <= S_WACK;
          end
          S_WACK: begin
            sda_oe <= 1'b0;
            cnt <= '0;
            st <= S_WDAT;
          end
          S_RDAT: begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              st <= S_RACK;
            end else begin
              sda_oe <= ~tsh[3'd7 - cnt[2:0]];
            end
          end
          S_RACK: begin
            tsh <= tx_byte;
            sda_oe <= ~tx_byte[7];
            rp <= rp + 1'b1;
            cnt <= '0;
            st <= S_RDAT;
          end
          default: ;
        endcase
      end

      if (cpu_wp_wr) wp <= cpu_wdata[PW-1:0];
      if (cpu_rp_wr) rp <= cpu_wdata[PW-1:0];
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr < A_TX) cpu_rdata = rx_mem[cpu_addr[WW-1:0]];
    else if (cpu_addr < A_WP) cpu_rdata = tx_mem[cpu_addr[WW-1:0]];
    else if (cpu_addr == A_WP) cpu_rdata = 32'(wp);
    else if (cpu_addr == A_RP) cpu_rdata = 32'(rp);
    else if (cpu_addr == A_EN) cpu_rdata = {31'd0, irq_en};
    else if (cpu_addr == A_ST) cpu_rdata = {31'd0, irq_st};
  end

  // R1
  quiet_when_unaddressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP || st == S_IDLE) |-> !sda_oe);

  // R2
  drive_only_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R4
  wp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp != $past(wp)) && !$past(cpu_wp_wr) |-> wp == $past(wp) + 1'b1);

  // R4
  rp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rp != $past(rp)) && !$past(cpu_rp_wr) |-> rp == $past(rp) + 1'b1);

  // R6
  status_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_st) |-> $past(stop_evt));

  // R6
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_clr && !(stop_evt && wr_act)) |-> !irq_st);

  // R8
  restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> st == S_ADDR && cnt == 4'd0);
endmodule

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [5:0] A_TX = 6'h10, A_WP = 6'h20, A_RP = 6'h21, A_EN = 6'h22, A_ST = 6'h23;
  // {address byte, data byte, expect acknowledge}
  localparam logic [16:0] VEC [5] = '{
    {8'hA0, 8'h11, 1'b1},
    {8'hA0, 8'h22, 1'b1},
    {8'hA2, 8'h33, 1'b0},
    {8'h20, 8'h55, 1'b0},
    {8'hA0, 8'h44, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic scl_drv = 1, sda_drv = 1;
  logic cpu_we = 0;
  logic [5:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic sda_oe, irq;
  wire sda_line = sda_drv & ~sda_oe;

  int n_run = 0, n_fail = 0;
  bit done = 0, mon = 0, saw_low = 0;
  int exp_wp = 0;

  i2c_regfile_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(negedge clk) if (mon && sda_oe) saw_low = 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_we = 0;
  endtask

  task automatic cpu_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); cpu_addr = a; #1; d = cpu_rdata;
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    wq(); sda_drv = b;
    wq(); scl_drv = 1;
    wq(); s = sda_line;
    wq(); scl_drv = 0;
  endtask

  task automatic i2c_start();
    wq(); sda_drv = 0;
    wq(); scl_drv = 0;
  endtask

  task automatic i2c_restart();
    wq(); sda_drv = 1;
    wq(); scl_drv = 1;
    wq(); sda_drv = 0;
    wq(); scl_drv = 0;
  endtask

  task automatic i2c_stop();
    wq(); sda_drv = 0;
    wq(); scl_drv = 1;
    wq(); sda_drv = 1;
    wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      b[i] = s;
    end
    bit_xfer(nack, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic ack;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    chk("R9 sda_oe in reset", {31'd0, sda_oe}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    cpu_rd(A_WP, d); chk("R9 write pointer", d, 0);
    cpu_rd(A_RP, d); chk("R9 read pointer", d, 0);
    cpu_rd(A_ST, d); chk("R9 status", d, 0);
    cpu_rd(A_EN, d); chk("R9 enable", d, 0);
    chk("R9 irq", {31'd0, irq}, 0);

    cpu_wr(A_EN, 1);
    foreach (VEC[k]) begin
      cpu_wr(A_ST, 1);
      i2c_start();
      wr_byte(VEC[k][16:9], ack);
      chk("R1 address acknowledge", {31'd0, ack}, {31'd0, VEC[k][0]});
      saw_low = 0; mon = 1;
      wr_byte(VEC[k][8:1], ack);
      mon = 0;
      if (VEC[k][0]) begin
        chk("R2 data acknowledge", {31'd0, ack}, 1);
        exp_wp++;
      end else begin
        chk("R1 SDA released after mismatch", {31'd0, saw_low}, 0);
      end
      i2c_stop();
      cpu_rd(A_ST, d); chk("R6 status after STOP", d, {31'd0, VEC[k][0]});
      chk("R6 irq after STOP", {31'd0, irq}, {31'd0, VEC[k][0]});
      cpu_rd(A_WP, d); chk("R2 write pointer", d, exp_wp);
    end
    cpu_rd(6'h00, d); chk("R2 lane placement", d, 32'h00442211);

    cpu_wr(6'h00, 32'hDEADBEEF);
    cpu_rd(6'h00, d); chk("R10 receive word ignores CPU", d, 32'h00442211);
    cpu_wr(A_TX, 32'h44332211);
    cpu_rd(A_TX, d); chk("R10 transmit word readback", d, 32'h44332211);

    cpu_wr(A_EN, 0); chk("R6 irq gated by enable", {31'd0, irq}, 0);
    cpu_wr(A_EN, 1); chk("R6 irq with enable", {31'd0, irq}, 1);
    cpu_wr(A_ST, 0); cpu_rd(A_ST, d); chk("R6 write 0 keeps status", d, 1);
    cpu_wr(A_ST, 1); cpu_rd(A_ST, d); chk("R6 write 1 clears status", d, 0);
    chk("R6 irq after clear", {31'd0, irq}, 0);

    cpu_wr(A_RP, 0);
    i2c_start();
    wr_byte(8'hA1, ack); chk("R1 read address acknowledge", {31'd0, ack}, 1);
    rd_byte(0, b); chk("R3 read byte 0", {24'd0, b}, 32'h11);
    rd_byte(0, b); chk("R3 read byte 1", {24'd0, b}, 32'h22);
    rd_byte(1, b); chk("R3 read byte 2", {24'd0, b}, 32'h33);
    saw_low = 0; mon = 1;
    for (int i = 0; i < 9; i++) bit_xfer(1'b1, ack);
    mon = 0;
    chk("R7 silent after NACK", {31'd0, saw_low}, 0);
    i2c_stop();
    cpu_rd(A_RP, d); chk("R3 read pointer", d, 3);
    cpu_rd(A_ST, d); chk("R6 read leaves status", d, 0);

    cpu_wr(A_TX, 32'hFFFFFFFF);
    cpu_wr(A_RP, 0);
    i2c_start();
    wr_byte(8'hA1, ack);
    rd_byte(1, b); chk("R10 preset reads 0xFF", {24'd0, b}, 32'hFF);
    i2c_stop();

    cpu_wr(A_WP, 62);
    cpu_rd(A_WP, d); chk("R5 write pointer load", d, 62);
    i2c_start();
    wr_byte(8'hA0, ack);
    wr_byte(8'hA5, ack);
    wr_byte(8'h5A, ack);
    wr_byte(8'hC3, ack);
    i2c_stop();
    cpu_rd(A_WP, d); chk("R4 write pointer wrap", d, 1);
    cpu_rd(6'h0F, d); chk("R4 last word lanes", d, 32'h5AA50000);
    cpu_rd(6'h00, d); chk("R4 wrapped byte", d, 32'h004422C3);

    cpu_wr(6'h1F, 32'h99000000);
    cpu_wr(A_RP, 63);
    i2c_start();
    wr_byte(8'hA1, ack);
    rd_byte(0, b); chk("R4 read byte 63", {24'd0, b}, 32'h99);
    rd_byte(1, b); chk("R4 read wrap to byte 0", {24'd0, b}, 32'hFF);
    i2c_stop();
    cpu_rd(A_RP, d); chk("R4 read pointer wrap", d, 1);

    cpu_wr(A_WP, 0); cpu_rd(A_WP, d); chk("R5 write pointer zero", d, 0);
    cpu_wr(A_RP, 0); cpu_rd(A_RP, d); chk("R5 read pointer zero", d, 0);

    cpu_wr(A_ST, 1);
    i2c_start();
    wr_byte(8'hA0, ack);
    wr_byte(8'h77, ack);
    i2c_restart();
    wr_byte(8'hA1, ack); chk("R8 address after repeated START", {31'd0, ack}, 1);
    rd_byte(1, b); chk("R8 read after repeated START", {24'd0, b}, 32'hFF);
    i2c_stop();
    cpu_rd(A_ST, d); chk("R8 no status after repeated START", d, 0);
    chk("R8 no irq", {31'd0, irq}, 0);
    cpu_rd(6'h00, d); chk("R8 byte before restart kept", d, 32'h00442277);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule